// File: doc/BRIEF.md
# Addressed ASCII Query Responder

This block sits behind a UART receiver and in front of a UART transmitter. It watches the incoming byte stream for one short query frame aimed at this node. The frame carries this node's address, a sender letter, an underscore, the letter 'Q', a one-letter command and a carriage return. When a complete frame arrives, the block picks one of four measurement words (power, voltage, current or line frequency) and sends back a seven-byte ASCII reply. The transmitter accepts one byte per valid/ready handshake.

The reply holds three data characters, one for each low-order nibble of the chosen value. Each character is the nibble with 0x30 added by bitwise OR, so the values 10 to 15 appear as the characters ':' to '?' and not as the letters A to F. A reset command does not select a measurement. Instead it pulses a request line to the converter front end, and like any unrecognised command it replies with zero. The serial bit timing is handled outside this block.

Top module: `qry_responder`

## Requirements
- R1: While waiting for a frame, the parser leaves the waiting state only on a valid byte equal to NODE_ADDR (default 0x52, 'R'). Every other byte keeps it waiting.
- R2: The byte after the address must be an uppercase letter (0x41 to 0x5A). The byte after that must be 0x5F ('_'), and the next one must be 0x51 ('Q'). On a mismatch the parser goes back to waiting, and the mismatching byte is not itself taken as an address.
- R3: The fifth byte of a frame is taken as the command. The frame is accepted only if the sixth byte is 0x0D. In both cases the parser then goes back to waiting.
- R4: Command 0x50 ('P') replies with pwr_val, 0x56 ('V') with volt_val, 0x49 ('I') with amp_val and 0x46 ('F') with freq_val.
- R5: Command 0x52 ('R') raises adc_reinit for exactly one cycle as its reply begins and replies with value 0. Any other unlisted command replies with 0 and leaves adc_reinit low.
- R6: A reply is exactly seven bytes, in this order: 0x43 ('C'), NODE_ADDR, 0x5F, three data characters, 0x0D.
- R7: The data characters are value bits [11:8], then [7:4], then [3:0], each OR-ed with 0x30.
- R8: A byte is passed only on a cycle where both tx_valid and tx_ready are high. While tx_ready is low, tx_valid stays high and tx_data does not change.
- R9: A frame accepted while a reply is being sent is kept. Its reply follows once the current reply ends. The value sent is the one sampled when that reply begins.
- R10: After reset, tx_valid and adc_reinit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| pwr_val | input | DATA_W | Power measurement |
| volt_val | input | DATA_W | Voltage measurement |
| amp_val | input | DATA_W | Current measurement |
| freq_val | input | DATA_W | Line frequency count |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | tx_data holds a reply byte |
| tx_data | output | 8 | Reply byte |
| adc_reinit | output | 1 | One-cycle request to re-initialise the converter interface |

## Verification
A parser left in the wrong state shows up as a missing reply or an extra reply. This is visible at tx_valid two cycles after the final carriage return of a frame. A pending flag that is lost or stuck shows up as a dropped reply or a repeated reply at the end of the current one. A wrong byte index or a wrong latched value shows up as a wrong character at the exact handshake that carries it. Stalls from a slow transmitter expose any byte that moves without tx_ready.

// File: rtl/qry_pkg.sv
package qry_pkg;

  typedef enum logic [2:0] {
    P_ADDR  = 3'd0,
    P_SRC   = 3'd1,
    P_DELIM = 3'd2,
    P_QRY   = 3'd3,
    P_ARG   = 3'd4,
    P_END   = 3'd5
  } parse_st_t;

  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_UNDER = 8'h5F;
  localparam logic [7:0] CH_Q     = 8'h51;
  localparam logic [7:0] CH_C     = 8'h43;

  localparam logic [7:0] CMD_PWR  = 8'h50;
  localparam logic [7:0] CMD_VOLT = 8'h56;
  localparam logic [7:0] CMD_AMP  = 8'h49;
  localparam logic [7:0] CMD_FREQ = 8'h46;
  localparam logic [7:0] CMD_RST  = 8'h52;

  function automatic logic is_upper(input logic [7:0] b);
    return (b >= 8'h41) && (b <= 8'h5A);
  endfunction

  function automatic logic [7:0] nib_char(input logic [3:0] n);
    return 8'h30 | {4'h0, n};
  endfunction

endpackage

// File: rtl/qry_frame_parser.sv
module qry_frame_parser
  import qry_pkg::*;
#(
  parameter logic [7:0] NODE_ADDR = 8'h52
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       frame_done,
  output logic [7:0] frame_cmd
);

  parse_st_t  st;
  logic [7:0] arg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= P_ADDR;
      arg_q      <= '0;
      frame_done <= 1'b0;
      frame_cmd  <= '0;
    end else begin
      frame_done <= 1'b0;
      if (rx_valid) begin
        case (st)
          P_ADDR:  if (rx_byte == NODE_ADDR) st <= P_SRC;
          P_SRC:   st <= is_upper(rx_byte) ? P_DELIM : P_ADDR;
          P_DELIM: st <= (rx_byte == CH_UNDER) ? P_QRY : P_ADDR;
          P_QRY:   st <= (rx_byte == CH_Q) ? P_ARG : P_ADDR;
          P_ARG: begin
            arg_q <= rx_byte;
            st    <= P_END;
          end
          P_END: begin
            st <= P_ADDR;
            if (rx_byte == CH_CR) begin
              frame_done <= 1'b1;
              frame_cmd  <= arg_q;
            end
          end
          default: st <= P_ADDR;
        endcase
      end
    end
  end

endmodule

// File: rtl/qry_cmd_hold.sv
module qry_cmd_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  logic [7:0] frame_cmd,
  input  logic       reply_start,
  output logic       cmd_pend,
  output logic [7:0] cmd_q
);

  // A newly accepted frame wins over the clear from a reply that starts in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_pend <= 1'b0;
      cmd_q    <= '0;
    end else if (frame_done) begin
      cmd_pend <= 1'b1;
      cmd_q    <= frame_cmd;
    end else if (reply_start) begin
      cmd_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/qry_data_select.sv
module qry_data_select
  import qry_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [7:0]        cmd,
  input  logic [DATA_W-1:0] pwr_val,
  input  logic [DATA_W-1:0] volt_val,
  input  logic [DATA_W-1:0] amp_val,
  input  logic [DATA_W-1:0] freq_val,
  output logic [DATA_W-1:0] value,
  output logic              is_reinit
);

  always_comb begin
    value     = '0;
    is_reinit = 1'b0;
    case (cmd)
      CMD_PWR:  value = pwr_val;
      CMD_VOLT: value = volt_val;
      CMD_AMP:  value = amp_val;
      CMD_FREQ: value = freq_val;
      CMD_RST:  is_reinit = 1'b1;
      default:  value = '0;
    endcase
  end

endmodule

// File: rtl/qry_reply_tx.sv
module qry_reply_tx
  import qry_pkg::*;
#(
  parameter logic [7:0] NODE_ADDR = 8'h52,
  parameter int DATA_W  = 16,
  parameter int NIBBLES = 3,
  localparam int REPLY_LEN = NIBBLES + 4,
  localparam int IDX_W = $clog2(REPLY_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reply_start,
  input  logic [DATA_W-1:0] reply_value,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              busy,
  output logic [IDX_W-1:0]  reply_idx
);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] val_q;
  logic              busy_q;
  logic [7:0]        dchar [NIBBLES];

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign dchar[g] = nib_char(val_q[4*(NIBBLES-1-g) +: 4]);
  end

  always_comb begin
    tx_data = CH_CR;
    if (idx == IDX_W'(0))      tx_data = CH_C;
    else if (idx == IDX_W'(1)) tx_data = NODE_ADDR;
    else if (idx == IDX_W'(2)) tx_data = CH_UNDER;
    else begin
      for (int k = 0; k < NIBBLES; k++) begin
        if (idx == IDX_W'(k + 3)) tx_data = dchar[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx    <= '0;
      val_q  <= '0;
    end else if (!busy_q) begin
      if (reply_start) begin
        busy_q <= 1'b1;
        idx    <= '0;
        val_q  <= reply_value;
      end
    end else if (tx_ready) begin
      if (idx == IDX_W'(REPLY_LEN - 1)) busy_q <= 1'b0;
      else idx <= idx + IDX_W'(1);
    end
  end

  assign tx_valid  = busy_q;
  assign busy      = busy_q;
  assign reply_idx = idx;

endmodule

// File: rtl/qry_responder.sv
module qry_responder
  import qry_pkg::*;
#(
  parameter logic [7:0] NODE_ADDR = 8'h52,
  parameter int DATA_W  = 16,
  parameter int NIBBLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [DATA_W-1:0] pwr_val,
  input  logic [DATA_W-1:0] volt_val,
  input  logic [DATA_W-1:0] amp_val,
  input  logic [DATA_W-1:0] freq_val,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              adc_reinit
);

  localparam int REPLY_LEN = NIBBLES + 4;
  localparam int IDX_W     = $clog2(REPLY_LEN);

  logic              frame_done;
  logic [7:0]        frame_cmd;
  logic              cmd_pend;
  logic [7:0]        cmd_q;
  logic              reply_start;
  logic              tx_busy;
  logic [DATA_W-1:0] sel_value;
  logic              sel_reinit;
  logic [IDX_W-1:0]  reply_idx;

  qry_frame_parser #(.NODE_ADDR(NODE_ADDR)) u_parse (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_done(frame_done), .frame_cmd(frame_cmd)
  );

  qry_cmd_hold u_hold (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_cmd(frame_cmd),
    .reply_start(reply_start), .cmd_pend(cmd_pend), .cmd_q(cmd_q)
  );

  qry_data_select #(.DATA_W(DATA_W)) u_sel (
    .cmd(cmd_q), .pwr_val(pwr_val), .volt_val(volt_val), .amp_val(amp_val),
    .freq_val(freq_val), .value(sel_value), .is_reinit(sel_reinit)
  );

  assign reply_start = cmd_pend && !tx_busy;
  assign adc_reinit  = reply_start && sel_reinit;

  qry_reply_tx #(.NODE_ADDR(NODE_ADDR), .DATA_W(DATA_W), .NIBBLES(NIBBLES)) u_tx (
    .clk(clk), .rst_n(rst_n), .reply_start(reply_start), .reply_value(sel_value),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .busy(tx_busy), .reply_idx(reply_idx)
  );

endmodule

// File: rtl/qry_responder_chk.sv
module qry_responder_chk #(
  parameter int REPLY_LEN = 7,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [7:0]       rx_byte,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             adc_reinit,
  input logic             frame_done,
  input logic             reply_start,
  input logic             cmd_pend,
  input logic [IDX_W-1:0] reply_idx
);

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r6_opens_with_c: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == 8'h43);

  a_r6_cr_closes: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_data == 8'h0D |=> !tx_valid);

  a_r7_data_char_range: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && reply_idx >= IDX_W'(3) && reply_idx <= IDX_W'(REPLY_LEN - 2)
      |-> tx_data[7:4] == 4'h3);

  a_r3_accept_needs_cr: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(rx_valid && rx_byte == 8'h0D));

  a_r5_reinit_starts_reply: assert property (@(posedge clk) disable iff (!rst_n)
    adc_reinit |=> tx_valid && tx_data == 8'h43 && !adc_reinit);

  a_r9_pend_cleared_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    reply_start |=> !cmd_pend || $past(frame_done));

endmodule

bind qry_responder qry_responder_chk #(.REPLY_LEN(REPLY_LEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .adc_reinit(adc_reinit), .frame_done(frame_done), .reply_start(reply_start),
  .cmd_pend(cmd_pend), .reply_idx(reply_idx)
);

// File: tb/qry_responder_test.sv
module qry_responder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [15:0] pwr_val = 16'hABCD;
  logic [15:0] volt_val = 16'h1234;
  logic [15:0] amp_val = 16'h0F0E;
  logic [15:0] freq_val = 16'h003C;
  logic        tx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        adc_reinit;

  always #2.5 clk = ~clk;

  qry_responder uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .pwr_val(pwr_val), .volt_val(volt_val), .amp_val(amp_val), .freq_val(freq_val),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .adc_reinit(adc_reinit)
  );

  int checks = 0;
  int failures = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'h5B;
  logic [7:0] cap [0:255];
  int cap_cnt = 0;
  int rst_pulses = 0;
  int cycles = 0;

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? 1'b0 : lfsr[0];
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap[cap_cnt[7:0]] <= tx_data;
      cap_cnt <= cap_cnt + 1;
    end
    if (rst_n && adc_reinit) rst_pulses <= rst_pulses + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                            input logic [7:0] q, input logic [7:0] c, input logic [7:0] e);
    send_byte(a); send_byte(s); send_byte(d); send_byte(q); send_byte(c); send_byte(e);
  endtask

  task automatic wait_cap(input int n);
    for (int i = 0; i < 3000 && cap_cnt < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic check_reply(input string req, input int base, input int v);
    chk(req, cap_cnt - base >= 7, 1);
    chk(req, cap[base], 8'h43);
    chk(req, cap[base+1], 8'h52);
    chk(req, cap[base+2], 8'h5F);
    chk(req, cap[base+3], 8'h30 + ((v / 256) % 16));
    chk(req, cap[base+4], 8'h30 + ((v / 16) % 16));
    chk(req, cap[base+5], 8'h30 + (v % 16));
    chk(req, cap[base+6], 8'h0D);
  endtask

  task automatic test_reset;
    chk("R10 tx_valid", tx_valid, 0);
    chk("R10 adc_reinit", adc_reinit, 0);
  endtask

  task automatic test_basic_queries;
    int b;
    b = cap_cnt; send_frame("R", "A", "_", "Q", "P", 8'h0D); wait_cap(b + 7); idle(3);
    check_reply("R4 R6 R7 power", b, 16'hABCD);
    chk("R6 exact length", cap_cnt - b, 7);
    b = cap_cnt; send_frame("R", "Z", "_", "Q", "V", 8'h0D); wait_cap(b + 7); idle(3);
    check_reply("R4 voltage", b, 16'h1234);
    b = cap_cnt; send_frame("R", "M", "_", "Q", "F", 8'h0D); wait_cap(b + 7); idle(3);
    check_reply("R4 frequency", b, 16'h003C);
  endtask

  task automatic test_backpressure;
    int b;
    b = cap_cnt;
    ready_mode = 1;
    send_frame("R", "B", "_", "Q", "I", 8'h0D);
    idle(8);
    chk("R8 valid while stalled", tx_valid, 1);
    chk("R8 first byte held", tx_data, 8'h43);
    chk("R8 nothing passed", cap_cnt - b, 0);
    idle(6);
    chk("R8 still held", tx_data, 8'h43);
    ready_mode = 2;
    wait_cap(b + 7); idle(3);
    ready_mode = 0;
    check_reply("R8 R4 current under random ready", b, 16'h0F0E);
  endtask

  task automatic test_bad_frames;
    int b;
    b = cap_cnt;
    send_frame("X", "A", "_", "Q", "P", 8'h0D);
    idle(20);
    chk("R1 wrong address ignored", cap_cnt - b, 0);
    send_byte("R"); send_byte("r"); send_byte("_"); send_byte("Q"); send_byte("P"); send_byte(8'h0D);
    idle(20);
    chk("R2 lowercase sender ignored", cap_cnt - b, 0);
    send_byte("R"); send_byte("A"); send_byte("-"); send_byte("Q"); send_byte("P"); send_byte(8'h0D);
    idle(20);
    chk("R2 wrong delimiter ignored", cap_cnt - b, 0);
    send_byte("R"); send_byte("A"); send_byte("_"); send_byte("X"); send_byte("P"); send_byte(8'h0D);
    idle(20);
    chk("R2 wrong query letter ignored", cap_cnt - b, 0);
    send_frame("R", "A", "_", "Q", "P", "X");
    idle(20);
    chk("R3 missing CR ignored", cap_cnt - b, 0);
    chk("R3 no stray valid", tx_valid, 0);
    send_frame("R", "A", "_", "Q", "V", 8'h0D);
    wait_cap(b + 7); idle(3);
    check_reply("R3 parser back to waiting", b, 16'h1234);
  endtask

  task automatic test_reinit_and_unknown;
    int b;
    int p;
    b = cap_cnt; p = rst_pulses;
    send_frame("R", "A", "_", "Q", "R", 8'h0D); wait_cap(b + 7); idle(3);
    check_reply("R5 reset command zero", b, 0);
    chk("R5 one reinit pulse", rst_pulses - p, 1);
    b = cap_cnt; p = rst_pulses;
    send_frame("R", "A", "_", "Q", "Z", 8'h0D); wait_cap(b + 7); idle(3);
    check_reply("R5 unknown command zero", b, 0);
    chk("R5 no reinit on unknown", rst_pulses - p, 0);
  endtask

  task automatic test_pending;
    int b;
    b = cap_cnt;
    pwr_val = 16'h0123;
    ready_mode = 1;
    send_frame("R", "A", "_", "Q", "P", 8'h0D);
    idle(5);
    pwr_val = 16'h0FFF;
    send_frame("R", "A", "_", "Q", "V", 8'h0D);
    idle(4);
    chk("R9 still stalled", cap_cnt - b, 0);
    ready_mode = 0;
    wait_cap(b + 14); idle(10);
    check_reply("R9 first reply value at start", b, 16'h0123);
    check_reply("R9 queued reply follows", b + 7, 16'h1234);
    chk("R9 exactly two replies", cap_cnt - b, 14);
    pwr_val = 16'hABCD;
  endtask

  initial begin
    idle(4);
    test_reset;
    rst_n = 1'b1;
    idle(3);
    test_reset;
    test_basic_queries;
    test_backpressure;
    test_bad_frames;
    test_reinit_and_unknown;
    test_pending;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule